// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a write-only control port that loads a bank of thirty 8-bit configuration registers from a three-wire serial link: an active-low select, a serial clock and a data line. All three lines are brought into the master-clock domain by a two-flop synchronizer. A data bit is taken on every detected rising edge of the serial clock while the select is low.

Within one select-low window, the first complete byte names a register address. Every later byte is data for that address, and then for the next one up. Once the running address passes the last implemented register (1Dh), further data is dropped. The address holds there and never returns to 00h.

The register contents drive a flat parallel output. A one-cycle write strobe and the written index mark each accepted data byte. A synchronous active-high reset loads every register with its defined power-on value.

Top module: `serial_cfg_port`

## Requirements
- R1: While `rst` is high at a clock edge, every register takes its power-on value. By index 00h..1Dh the values are: 00,00,11,3D,86,0E,0E,0E,04,00,00,A3,80,80,2E,0B,01,18,11,11,30,56,00,00,00,04,00,00,01,00 (hex).
- R2: Bits are shifted in most significant first. The first byte after the select falls is an address, and each following byte is data.
- R3: Within one burst, each data byte after the first goes to the previous target index plus one.
- R4: A data byte whose target index is 1Eh or above changes no register and raises no strobe. The running address saturates and never wraps back to 00h, even after 256 or more further bytes.
- R5: A partial byte cut off by the select going high is discarded. The next select-low window starts again with a fresh address byte.
- R6: `wr_stb` is high for exactly one clock cycle for each accepted data byte. It stays low for address bytes and dropped bytes, and no register changes without it.
- R7: Serial clock edges that occur while the select is high have no effect.
- R8: Register n appears on `cfg_regs[8n+7:8n]`.
- R9: While `wr_stb` is high, `wr_index` shows the index of the register just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel_n | input | 1 | Active-low transfer select |
| ser_clk | input | 1 | Serial bit clock, at most a quarter of `clk` |
| ser_din | input | 1 | Serial data, MSB first |
| cfg_regs | output | 240 | All registers, register n at bits 8n+7:8n |
| wr_stb | output | 1 | One-cycle pulse per accepted data byte |
| wr_index | output | 8 | Index written while `wr_stb` is high |

## Verification
Two functions can meet in the same cycle: the saturating address advance and the completion of a byte that targets the boundary. The last valid write to 1Dh and the first dropped byte are decided by the same counter. The bench provokes this with bursts that start just below 1Dh and with a burst of 257 bytes that starts at 1Dh. It judges the result by the full register image and by the strobe count. Interrupted bytes and serial clocks sent while the select is idle are judged the same way, against a model that the bench updates by address arithmetic.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int REG_COUNT = 30;
    localparam int BYTE_W    = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // One completed serial byte and its role
    typedef struct packed {
        logic  valid;
        logic  is_data;
        byte_t target;
        byte_t value;
    } byte_evt_t;

    function automatic byte_t power_on_value(input byte_t idx);
        case (idx)
            8'h02: return 8'h11;
            8'h03: return 8'h3D;
            8'h04: return 8'h86;
            8'h05, 8'h06, 8'h07: return 8'h0E;
            8'h08: return 8'h04;
            8'h0B: return 8'hA3;
            8'h0C, 8'h0D: return 8'h80;
            8'h0E: return 8'h2E;
            8'h0F: return 8'h0B;
            8'h10: return 8'h01;
            8'h11: return 8'h18;
            8'h12, 8'h13: return 8'h11;
            8'h14: return 8'h30;
            8'h15: return 8'h56;
            8'h19: return 8'h04;
            8'h1C: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfgport_sync.sv
module cfgport_sync #(
    parameter int              WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic stage1, stage2;
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1 <= RST_VAL[i];
                stage2 <= RST_VAL[i];
            end else begin
                stage1 <= d[i];
                stage2 <= stage1;
            end
        end
        assign q[i] = stage2;
    end
endmodule

// File: rtl/cfgport_deser.sv
module cfgport_deser
    import cfgport_pkg::*;
#(
    parameter int NUM_REGS = REG_COUNT
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sel_n_s,
    input  logic      sclk_s,
    input  logic      din_s,
    output byte_evt_t evt
);
    localparam byte_t LIMIT = byte_t'(NUM_REGS);

    logic        sclk_prev;
    logic [6:0]  shift_q;
    logic [2:0]  bit_cnt;
    logic        in_data;
    byte_t       addr_q;
    logic        rise;
    byte_t       full_byte;

    assign rise      = sclk_s & ~sclk_prev;
    assign full_byte = {shift_q, din_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            shift_q   <= '0;
            bit_cnt   <= '0;
            in_data   <= 1'b0;
            addr_q    <= '0;
            evt       <= '0;
        end else begin
            sclk_prev <= sclk_s;
            evt.valid <= 1'b0;
            if (sel_n_s) begin
                bit_cnt <= '0;
                in_data <= 1'b0;
            end else if (rise) begin
                shift_q <= full_byte[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    evt <= '{valid: 1'b1, is_data: in_data,
                             target: addr_q, value: full_byte};
                    if (!in_data) begin
                        addr_q  <= full_byte;
                        in_data <= 1'b1;
                    end else if (addr_q < LIMIT) begin
                        addr_q <= addr_q + 8'd1;
                    end
                end
            end
        end
    end

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && evt.is_data && evt.target < LIMIT) |-> (addr_q == evt.target + 8'd1));
    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (in_data && addr_q >= LIMIT) |=> (addr_q == $past(addr_q)));
    assert_idle_restart_R5: assert property (@(posedge clk) disable iff (rst)
        sel_n_s |=> (bit_cnt == 3'd0 && !in_data));
    assert_evt_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        evt.valid |=> !evt.valid);
endmodule

// File: rtl/cfgport_regfile.sv
module cfgport_regfile
    import cfgport_pkg::*;
#(
    parameter int NUM_REGS = REG_COUNT
) (
    input  logic                         clk,
    input  logic                         rst,
    input  byte_evt_t                    evt,
    output logic [NUM_REGS*BYTE_W-1:0]   regs,
    output logic                         stb,
    output byte_t                        idx
);
    localparam byte_t LIMIT = byte_t'(NUM_REGS);

    logic wr_en;
    assign wr_en = evt.valid && evt.is_data && (evt.target < LIMIT);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i*BYTE_W +: BYTE_W] <= power_on_value(byte_t'(i));
            else if (wr_en && evt.target == byte_t'(i))
                regs[i*BYTE_W +: BYTE_W] <= evt.value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb <= 1'b0;
            idx <= '0;
        end else begin
            stb <= wr_en;
            if (wr_en) idx <= evt.target;
        end
    end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import cfgport_pkg::*;
#(
    parameter int NUM_REGS = REG_COUNT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ser_sel_n,
    input  logic                       ser_clk,
    input  logic                       ser_din,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_regs,
    output logic                       wr_stb,
    output logic [BYTE_W-1:0]          wr_index
);
    logic [2:0] sync_q;
    byte_evt_t  evt;

    cfgport_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_sel_n, ser_clk, ser_din}),
        .q   (sync_q)
    );

    cfgport_deser #(.NUM_REGS(NUM_REGS)) u_deser (
        .clk     (clk),
        .rst     (rst),
        .sel_n_s (sync_q[2]),
        .sclk_s  (sync_q[1]),
        .din_s   (sync_q[0]),
        .evt     (evt)
    );

    cfgport_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .regs (cfg_regs),
        .stb  (wr_stb),
        .idx  (wr_index)
    );

    assert_change_needs_stb_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_regs) |-> wr_stb);
    assert_stb_single_R6: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);
    assert_index_valid_R9: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (wr_index < BYTE_W'(NUM_REGS)));
endmodule

// File: tb/test_serial_cfg_port.sv
module test_serial_cfg_port;
    localparam int N = 30;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           sel_n = 1'b1;
    logic           sclk = 1'b0;
    logic           din = 1'b0;
    logic [N*8-1:0] regs;
    logic           wr_stb;
    logic [7:0]     wr_index;

    int  tests = 0;
    int  fails = 0;
    int  stb_cnt = 0;
    int  cycles = 0;
    bit  done = 0;
    logic [7:0] last_idx = '0;
    logic [7:0] exp_r [N];
    int  exp_stb = 0;

    serial_cfg_port i_serial_cfg_port (
        .clk(clk), .rst(rst), .ser_sel_n(sel_n), .ser_clk(sclk),
        .ser_din(din), .cfg_regs(regs), .wr_stb(wr_stb), .wr_index(wr_index)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (wr_stb) begin
            stb_cnt  <= stb_cnt + 1;
            last_idx <= wr_index;
        end
        if (cycles == 190000 && !done) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog act=%0d exp=done", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [7:0] init_val(int i);
        case (i)
            2: return 8'h11;  3: return 8'h3D;  4: return 8'h86;
            5, 6, 7: return 8'h0E;  8: return 8'h04;  11: return 8'hA3;
            12, 13: return 8'h80;  14: return 8'h2E;  15: return 8'h0B;
            16: return 8'h01; 17: return 8'h18; 18, 19: return 8'h11;
            20: return 8'h30; 21: return 8'h56; 25: return 8'h04;
            28: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        @(negedge clk);
        din = b; sclk = 1'b0;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int b = 7; b >= 0; b--) send_bit(v[b]);
    endtask

    task automatic sel_begin();
        @(negedge clk);
        sel_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic sel_end();
        @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        sel_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // Model: write to index, drop above the last register, saturate
    task automatic burst(logic [7:0] start, int count, logic [7:0] seed);
        int a;
        a = start;
        sel_begin();
        send_byte(start);
        for (int k = 0; k < count; k++) begin
            logic [7:0] v;
            v = 8'(seed + 8'(k * 37));
            send_byte(v);
            if (a < N) begin
                exp_r[a] = v;
                exp_stb  = exp_stb + 1;
                a = a + 1;
            end
        end
        sel_end();
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < N; i++)
            chk(req, {24'h0, regs[8*i +: 8]}, {24'h0, exp_r[i]});
        chk({req, " strobes"}, stb_cnt, exp_stb);
    endtask

    initial begin
        for (int i = 0; i < N; i++) exp_r[i] = init_val(i);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 reset R8");

        // R2/R9: single write to each index
        for (int a = 0; a < N; a++) begin
            burst(8'(a), 1, 8'(a * 7 + 8'h35));
            chk("R9 index", {24'h0, last_idx}, a);
        end
        check_all("R2 single");

        // R3: full burst from 00h
        burst(8'h00, N, 8'hC1);
        check_all("R3 burst");

        // R4: straddle the top, address byte above range, no wrap
        burst(8'h1C, 4, 8'h9E);
        check_all("R4 straddle");
        burst(8'h40, 2, 8'h77);
        check_all("R4 out of range");
        burst(8'h1D, 257, 8'h5A);
        check_all("R4 no wrap");

        // R5: data byte cut off, then address byte cut off
        sel_begin();
        send_byte(8'h05);
        for (int b = 0; b < 4; b++) send_bit(1'b1);
        sel_end();
        check_all("R5 cut data");
        burst(8'h06, 1, 8'hAB);
        check_all("R5 restart");
        sel_begin();
        for (int b = 0; b < 3; b++) send_bit(1'b0);
        sel_end();
        burst(8'h08, 1, 8'hC3);
        check_all("R5 cut address");

        // R7: clocks while idle
        send_byte(8'h03);
        send_byte(8'hFF);
        @(negedge clk); sclk = 1'b0;
        repeat (4) @(negedge clk);
        check_all("R7 idle clocks");
        burst(8'h07, 1, 8'h5A);
        check_all("R7 after idle");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule